// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block turns single read or write requests from a 16-bit core into cycles on an external bus. The address space is split into three kinds of region: a small special-function region at the bottom of the map, an internal memory region, and four chip-select windows in the upper half. An external cycle has an address phase and a strobe phase. Between them the controller can insert software wait clocks, set separately for each chip-select window. A strobe that has used up its programmed waits can be stretched further by an external ready input.

Special-function cycles have a fixed length of two or three clocks, chosen by one mode bit. They ignore the per-window wait settings and the ready input. Internal accesses finish in one clock and leave the pins parked: strobes and selects high, ALE low, address and byte-high enable frozen. The core holds its request until it sees a one-clock acknowledge. Read data is valid while that acknowledge is high.

The configuration port rejects any write that would leave the wait settings inconsistent. A rejected write changes nothing and raises a one-clock error pulse.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: After reset, every chip-select window has waits enabled (no-wait bits 0) and a wait code of 00, and special-function cycles are short. The pins are idle: cs_n all ones, rd_n, wr_n, wrl_n, wrh_n and bhe_n high, ale low, bus_doe low. ack and cfg_err are low.
- R2: A write with cfg_sel=1 loads the wait-code register. Window i uses bits [2i+1:2i]. Code 00 gives 1 wait clock, 01 gives 2 and 10 gives 3. A write that contains the code 11 in any field is rejected.
- R3: A write with cfg_sel=0 loads the no-wait bits, with bit i for window i. Two writes are rejected: a wait-code write that gives a nonzero code to a window whose no-wait bit is 1, and a no-wait write that sets bit i to 1 while the code of window i is nonzero.
- R4: A rejected write leaves all configuration unchanged. cfg_err is high for exactly the one clock after the write edge, and it stays low after accepted writes.
- R5: An access with req_addr[19]=1 is external, and its window is req_addr[18:17]. The cycle lasts 2 clocks when the window's no-wait bit is 1, and 2+n clocks when waits are enabled, where n is the coded wait count.
- R6: In the first clock of an external cycle, ale is high and only the selected cs_n bit is low, with bus_addr equal to the request address. That cs_n bit stays low through the strobe phase.
- R7: For a window with waits enabled, rdy is sampled at the end of the strobe. The strobe repeats for every clock in which rdy is low. For a no-wait window, rdy has no effect on the cycle length.
- R8: An access with req_addr[19]=0 and req_addr[18:10] nonzero is internal. It takes 1 clock. During that clock all cs_n bits and all strobes are high, ale and bus_doe are low, and bus_addr and bhe_n keep their previous values.
- R9: An access with req_addr[19:10]=0 is a special-function cycle. It lasts 2 clocks, or 3 clocks when bit 0 of a cfg_sel=2 write is 1. It drives bus_addr and the strobes but no chip select and no ale, and it ignores the wait codes and rdy.
- R10: ack is high for exactly one clock, the clock after the last bus clock. On reads, rdata holds the bus_din value sampled on the completing edge.
- R11: During the strobe phase, rd_n is low for reads. For writes, wr_n is low, wrl_n is low if req_be[0] is set, wrh_n is low if req_be[1] is set, and bus_doe is high with bus_dout equal to the write data. bhe_n is the inverse of req_be[1], latched at the start of each external or special-function cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Core access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 no-wait bits, 1 wait codes, 2 special-function length |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_err | output | 1 | One-clock pulse on a rejected write |
| bus_addr | output | 20 | Bus address |
| bus_dout | output | 16 | Bus write data |
| bus_doe | output | 1 | Bus data output enable |
| bus_din | input | 16 | Bus read data |
| rdy | input | 1 | External ready, low stretches the strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| wrl_n | output | 1 | Low-byte write strobe |
| wrh_n | output | 1 | High-byte write strobe |
| bhe_n | output | 1 | Byte-high enable |
| cs_n | output | 4 | Chip selects, active low |
| ale | output | 1 | Address latch enable |

## Verification
If the stored wait codes or no-wait bits are wrong, the next access to the affected window shows a wrong count of clocks between request and acknowledge. The bench measures that count on every access. A guard that failed to reject a write shows up the same way, on the first access after the write, and a bad error flag shows up one clock after the write. A wrong region decode or a wrong parked-pin state is visible in the first clock of the cycle, through cs_n, ale and bus_addr, and the strobe pins are sampled again in the second clock.

// File: rtl/ebus_pkg.sv
// Shared types for the external bus wait-state controller.
// Assumes: one outstanding access at a time.
package ebus_pkg;

    // Region class of an access, decoded from the upper address bits
    typedef enum logic [1:0] {
        RGN_INT = 2'd0,
        RGN_SFR = 2'd1,
        RGN_EXT = 2'd2
    } region_e;

    // Bus sequencer states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INT  = 3'd1,
        ST_ADDR = 3'd2,
        ST_WAIT = 3'd3,
        ST_STRB = 3'd4
    } seq_state_e;

    // Configuration register selectors
    localparam logic [1:0] CFG_NOWAIT = 2'd0;
    localparam logic [1:0] CFG_WCODE  = 2'd1;
    localparam logic [1:0] CFG_SFRLEN = 2'd2;

endpackage

// File: rtl/ebus_cfg_regs.sv
// Configuration store: per-window no-wait bits, per-window wait codes and
// the special-function cycle length bit. Writes that would break the
// ordering rule or store the all-ones code are dropped as a whole and flag
// a one-clock error. Assumes cfg_we is a single-clock strobe.
module ebus_cfg_regs
    import ebus_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned FLD_W  = 2,
    localparam int unsigned CFG_DW = NUM_CS * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [CFG_DW-1:0] wdata,
    output logic [NUM_CS-1:0] nowait,
    output logic [CFG_DW-1:0] wcode,
    output logic              sfr_long,
    output logic              err
);

    logic [NUM_CS-1:0] code_rsvd;
    logic [NUM_CS-1:0] code_blocked;
    logic [NUM_CS-1:0] off_blocked;
    logic              reject;

    // Per-window legality checks of the incoming write data
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_chk
        assign code_rsvd[gi]    = &wdata[gi*FLD_W +: FLD_W];
        assign code_blocked[gi] = nowait[gi] && (wdata[gi*FLD_W +: FLD_W] != '0);
        assign off_blocked[gi]  = wdata[gi] && (wcode[gi*FLD_W +: FLD_W] != '0);

        AST_CODE_ZERO_IF_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
            nowait[gi] |-> (wcode[gi*FLD_W +: FLD_W] == '0)); // R3
        AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            !(&wcode[gi*FLD_W +: FLD_W])); // R2
    end

    // Decide whether the current write is dropped
    always_comb begin
        reject = 1'b0;
        if (we) begin
            if (sel == CFG_WCODE)
                reject = (|code_rsvd) || (|code_blocked);
            else if (sel == CFG_NOWAIT)
                reject = |off_blocked;
        end
    end

    // Register update and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nowait   <= '0;
            wcode    <= '0;
            sfr_long <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= reject;
            if (we && !reject) begin
                case (sel)
                    CFG_NOWAIT: nowait   <= wdata[NUM_CS-1:0];
                    CFG_WCODE:  wcode    <= wdata;
                    CFG_SFRLEN: sfr_long <= wdata[0];
                    default:    ;
                endcase
            end
        end
    end

    AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(nowait) && $stable(wcode) && $stable(sfr_long))); // R4
    AST_ERR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        err && !$past(we) |-> 1'b0); // R4

endmodule

// File: rtl/ebus_region_dec.sv
// Region decoder: the top address bit marks a chip-select window, the next
// bits pick the window. Below that an all-zero upper field is the
// special-function region and everything else is internal memory.
// Assumes NUM_CS is a power of two.
module ebus_region_dec
    import ebus_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned SFR_BITS = 10,
    parameter int unsigned NUM_CS   = 4,
    localparam int unsigned CS_IDX_W = $clog2(NUM_CS)
) (
    input  logic [ADDR_W-1:SFR_BITS] addr_hi,
    output region_e                  region,
    output logic [CS_IDX_W-1:0]      cs_idx
);

    // Classify the access from its upper address bits
    always_comb begin
        if (addr_hi[ADDR_W-1])
            region = RGN_EXT;
        else if (addr_hi[ADDR_W-2:SFR_BITS] == '0)
            region = RGN_SFR;
        else
            region = RGN_INT;
    end

    assign cs_idx = addr_hi[ADDR_W-2 -: CS_IDX_W];

endmodule

// File: rtl/ebus_cycle_seq.sv
// Bus cycle sequencer: accepts one request, runs the address phase, the
// counted wait clocks and the strobe phase, then pulses ack. It drives the
// bus pins from registered state. Internal accesses only park the pins for
// one clock. Assumes the request stays stable until ack.
module ebus_cycle_seq
    import ebus_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned FLD_W  = 2,
    localparam int unsigned CS_IDX_W = $clog2(NUM_CS),
    localparam int unsigned BE_W     = DATA_W / 8,
    localparam int unsigned CFG_DW   = NUM_CS * FLD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BE_W-1:0]     req_be,
    input  logic [DATA_W-1:0]   req_wdata,
    input  region_e             region,
    input  logic [CS_IDX_W-1:0] cs_idx,
    input  logic [NUM_CS-1:0]   nowait,
    input  logic [CFG_DW-1:0]   wcode,
    input  logic                sfr_long,
    input  logic [DATA_W-1:0]   bus_din,
    input  logic                rdy,
    output logic                ack,
    output logic [DATA_W-1:0]   rdata,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_doe,
    output logic                rd_n,
    output logic                wr_n,
    output logic                wrl_n,
    output logic                wrh_n,
    output logic                bhe_n,
    output logic [NUM_CS-1:0]   cs_n,
    output logic                ale
);

    seq_state_e          state;
    region_e             rgn_q;
    logic [CS_IDX_W-1:0] cs_q;
    logic                we_q;
    logic [BE_W-1:0]     be_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                bhe_n_q;
    logic                nowait_q;
    logic [FLD_W-1:0]    cnt_q;
    logic [FLD_W-1:0]    wait_load;
    logic [FLD_W-1:0]    code_sel;
    logic                strb_done;
    logic                active;
    logic                strobe_ph;

    // Wait clocks for the request being accepted
    always_comb begin
        code_sel = wcode[cs_idx*FLD_W +: FLD_W];
        if (region == RGN_SFR)
            wait_load = sfr_long ? FLD_W'(1) : '0;
        else if (nowait[cs_idx])
            wait_load = '0;
        else
            wait_load = code_sel + FLD_W'(1);
    end

    // The strobe ends unless a waited window sees ready low
    assign strb_done = (rgn_q == RGN_SFR) || nowait_q || rdy;

    // Cycle state machine and access capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rgn_q    <= RGN_INT;
            cs_q     <= '0;
            we_q     <= 1'b0;
            be_q     <= '0;
            wdata_q  <= '0;
            addr_q   <= '0;
            bhe_n_q  <= 1'b1;
            nowait_q <= 1'b0;
            cnt_q    <= '0;
            ack      <= 1'b0;
            rdata    <= '0;
        end else begin
            ack <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req && !ack) begin
                        rgn_q <= region;
                        we_q  <= req_we;
                        if (region == RGN_INT) begin
                            state <= ST_INT;
                        end else begin
                            state    <= ST_ADDR;
                            cs_q     <= cs_idx;
                            be_q     <= req_be;
                            wdata_q  <= req_wdata;
                            addr_q   <= req_addr;
                            bhe_n_q  <= ~req_be[BE_W-1];
                            nowait_q <= (region == RGN_EXT) && nowait[cs_idx];
                            cnt_q    <= wait_load;
                        end
                    end
                end
                ST_INT: begin
                    state <= ST_IDLE;
                    ack   <= 1'b1;
                end
                ST_ADDR: begin
                    state <= (cnt_q != '0) ? ST_WAIT : ST_STRB;
                end
                ST_WAIT: begin
                    cnt_q <= cnt_q - FLD_W'(1);
                    if (cnt_q == FLD_W'(1))
                        state <= ST_STRB;
                end
                ST_STRB: begin
                    if (strb_done) begin
                        state <= ST_IDLE;
                        ack   <= 1'b1;
                        if (!we_q)
                            rdata <= bus_din;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active    = (state == ST_ADDR) || (state == ST_WAIT) || (state == ST_STRB);
    assign strobe_ph = (state == ST_WAIT) || (state == ST_STRB);

    // Pin drive from the captured access
    assign bus_addr = addr_q;
    assign bus_dout = wdata_q;
    assign bus_doe  = strobe_ph && we_q;
    assign rd_n     = !(strobe_ph && !we_q);
    assign wr_n     = !(strobe_ph && we_q);
    assign wrl_n    = !(strobe_ph && we_q && be_q[0]);
    assign wrh_n    = !(strobe_ph && we_q && be_q[BE_W-1]);
    assign bhe_n    = bhe_n_q;
    assign ale      = (state == ST_ADDR) && (rgn_q == RGN_EXT);

    // One active-low select per window
    for (genvar gc = 0; gc < NUM_CS; gc++) begin : g_cs
        assign cs_n[gc] = !(active && (rgn_q == RGN_EXT) && (cs_q == CS_IDX_W'(gc)));
    end

    AST_ACK_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R10
    AST_ACK_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> ($past(state) == ST_STRB || $past(state) == ST_INT)); // R10
    AST_ALE_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !(&cs_n)); // R6
    AST_INT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT) |-> ((&cs_n) && rd_n && wr_n && wrl_n && wrh_n && !ale
                               && !bus_doe && $stable(bus_addr) && $stable(bhe_n))); // R8
    AST_SFR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rgn_q == RGN_SFR) |-> ((&cs_n) && !ale)); // R9
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_doe); // R11
    AST_NOWAIT_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRB && nowait_q) |=> (state != ST_STRB)); // R7

endmodule

// File: rtl/ebus_wait_ctrl.sv
// Top of the external bus wait-state controller: ties the configuration
// store, the region decoder and the cycle sequencer together.
// Assumes a single clock domain and a core that waits for ack.
module ebus_wait_ctrl
    import ebus_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NUM_CS   = 4,
    parameter int unsigned FLD_W    = 2,
    parameter int unsigned SFR_BITS = 10,
    localparam int unsigned CS_IDX_W = $clog2(NUM_CS),
    localparam int unsigned BE_W     = DATA_W / 8,
    localparam int unsigned CFG_DW   = NUM_CS * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              cfg_err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              rdy,
    output logic              rd_n,
    output logic              wr_n,
    output logic              wrl_n,
    output logic              wrh_n,
    output logic              bhe_n,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ale
);

    logic [NUM_CS-1:0]   nowait;
    logic [CFG_DW-1:0]   wcode;
    logic                sfr_long;
    region_e             region;
    logic [CS_IDX_W-1:0] cs_idx;

    ebus_cfg_regs #(
        .NUM_CS (NUM_CS),
        .FLD_W  (FLD_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .nowait   (nowait),
        .wcode    (wcode),
        .sfr_long (sfr_long),
        .err      (cfg_err)
    );

    ebus_region_dec #(
        .ADDR_W   (ADDR_W),
        .SFR_BITS (SFR_BITS),
        .NUM_CS   (NUM_CS)
    ) u_dec (
        .addr_hi (req_addr[ADDR_W-1:SFR_BITS]),
        .region  (region),
        .cs_idx  (cs_idx)
    );

    ebus_cycle_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_CS (NUM_CS),
        .FLD_W  (FLD_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .region    (region),
        .cs_idx    (cs_idx),
        .nowait    (nowait),
        .wcode     (wcode),
        .sfr_long  (sfr_long),
        .bus_din   (bus_din),
        .rdy       (rdy),
        .ack       (ack),
        .rdata     (rdata),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .wrl_n     (wrl_n),
        .wrh_n     (wrh_n),
        .bhe_n     (bhe_n),
        .cs_n      (cs_n),
        .ale       (ale)
    );

endmodule

// File: tb/ebus_wait_ctrl_tb.sv
// Self-checking bench: a vector table of accesses walked by one loop,
// then directed tests for reset, pins, configuration guards and corners.
module ebus_wait_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_err;
    logic [19:0] bus_addr;
    logic [15:0] bus_dout;
    logic        bus_doe;
    logic [15:0] bus_din = '0;
    logic        rdy = 1'b1;
    logic        rd_n, wr_n, wrl_n, wrh_n, bhe_n, ale;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;

    // First-clock and second-clock pin snapshots of the last access
    logic [19:0] sa_addr;
    logic [3:0]  sa_cs;
    logic        sa_ale, sa_rd, sa_wr, sa_doe, sa_bhe;
    logic        sb_rd, sb_wr, sb_wrl, sb_wrh, sb_doe, sb_bhe;
    logic [15:0] sb_dout;

    ebus_wait_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .rdy(rdy), .rd_n(rd_n), .wr_n(wr_n), .wrl_n(wrl_n), .wrh_n(wrh_n),
        .bhe_n(bhe_n), .cs_n(cs_n), .ale(ale)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d,
                             input bit exp_err, input string rq);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_err == exp_err, rq, int'(cfg_err), int'(exp_err));
        @(posedge clk);
        @(negedge clk);
        if (exp_err) chk(cfg_err == 1'b0, "R4 err one clock", int'(cfg_err), 0);
    endtask

    // Run one access; len is the edge index at which ack appears
    task automatic access(input logic [19:0] a, input logic w, input logic [1:0] be,
                          input logic [15:0] d, input int k, output int len);
        int idx;
        @(negedge clk);
        req = 1'b1; req_we = w; req_addr = a; req_be = be; req_wdata = d;
        bus_din = d; rdy = (k <= 0);
        idx = -1;
        len = 99;
        while (idx < 60) begin
            @(posedge clk);
            idx++;
            @(negedge clk);
            if (idx == 0) begin
                sa_addr = bus_addr; sa_cs = cs_n; sa_ale = ale; sa_rd = rd_n;
                sa_wr = wr_n; sa_doe = bus_doe; sa_bhe = bhe_n;
            end
            if (idx == 1) begin
                sb_rd = rd_n; sb_wr = wr_n; sb_wrl = wrl_n; sb_wrh = wrh_n;
                sb_doe = bus_doe; sb_bhe = bhe_n; sb_dout = bus_dout;
            end
            rdy = (idx + 1 >= k);
            if (ack) begin
                len = idx;
                req = 1'b0;
                break;
            end
        end
        req = 1'b0;
        rdy = 1'b1;
    endtask

    // Vector: addr, we, be, data, ready-low edges, expected clocks
    typedef struct packed {
        logic [19:0] addr;
        logic        we;
        logic [1:0]  be;
        logic [15:0] data;
        logic [3:0]  k;
        logic [3:0]  len;
    } vec_t;

    localparam int NV = 10;
    localparam logic [46:0] VECS [NV] = '{
        {20'h80010, 1'b0, 2'b11, 16'hA5A5, 4'd0, 4'd4},  // R5 CS0 two waits
        {20'hA0020, 1'b0, 2'b11, 16'h1357, 4'd0, 4'd2},  // R5 CS1 no wait
        {20'hC0000, 1'b1, 2'b01, 16'h2468, 4'd0, 4'd5},  // R5 CS2 three waits
        {20'hE1234, 1'b0, 2'b11, 16'hBEEF, 4'd0, 4'd3},  // R5 CS3 one wait
        {20'hE0002, 1'b0, 2'b10, 16'h0F0F, 4'd6, 4'd6},  // R7 ready stretch
        {20'hA0004, 1'b0, 2'b11, 16'h7777, 4'd7, 4'd2},  // R7 ready ignored
        {20'h00123, 1'b0, 2'b11, 16'hC3C3, 4'd0, 4'd2},  // R9 short SFR read
        {20'h003FE, 1'b1, 2'b11, 16'h5A5A, 4'd9, 4'd2},  // R9 SFR ignores ready
        {20'h40000, 1'b0, 2'b11, 16'h0000, 4'd0, 4'd1},  // R8 internal
        {20'h80100, 1'b1, 2'b11, 16'h9999, 4'd8, 4'd8}   // R7 waited write stretch
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len;
        vec_t v;
        logic [15:0] keep;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
        chk(rd_n && wr_n && wrl_n && wrh_n && bhe_n, "R1 strobes", {rd_n, wr_n, wrl_n, wrh_n, bhe_n}, 5'h1F);
        chk(!ale && !bus_doe && !ack && !cfg_err, "R1 ale/doe/ack/err",
            {ale, bus_doe, ack, cfg_err}, 0);
        rst_n = 1'b1;
        access(20'h80000, 1'b0, 2'b11, 16'h1111, 0, len);
        chk(len == 3, "R1 reset code one wait", len, 3);
        access(20'h00010, 1'b0, 2'b11, 16'h2222, 0, len);
        chk(len == 2, "R1 reset SFR short", len, 2);

        // Table configuration: CS0=01, CS2=10, CS1 no wait
        cfg_write(2'd1, 8'h21, 1'b0, "R2 legal code write");
        cfg_write(2'd0, 8'h02, 1'b0, "R3 legal nowait write");

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            keep = rdata;
            access(v.addr, v.we, v.be, v.data, int'(v.k), len);
            chk(len == int'(v.len), $sformatf("R5/R7/R8/R9 length vec %0d", i), len, int'(v.len));
            if (!v.we && (v.addr[19] || v.addr[19:10] == 10'd0))
                chk(rdata == v.data, $sformatf("R10 read data vec %0d", i), rdata, v.data);
            else if (!v.we)
                chk(rdata == keep, "R8 internal keeps rdata", rdata, keep);
        end

        // R6 / R11 external write pins on CS2
        access(20'hC0040, 1'b1, 2'b01, 16'h4321, 0, len);
        chk(sa_ale == 1'b1 && sa_cs == 4'b1011, "R6 ale and select", {sa_ale, sa_cs}, 5'h1B);
        chk(sa_addr == 20'hC0040, "R6 address", sa_addr, 20'hC0040);
        chk(!sb_wr && !sb_wrl && sb_wrh && sb_rd, "R11 write strobes",
            {sb_wr, sb_wrl, sb_wrh, sb_rd}, 4'b0011);
        chk(sb_doe && sb_dout == 16'h4321, "R11 data drive", {sb_doe, sb_dout}, {1'b1, 16'h4321});
        chk(sb_bhe == 1'b1, "R11 bhe from be", sb_bhe, 1);

        // R10 ack single clock
        @(negedge clk);
        chk(ack == 1'b0, "R10 ack one clock", ack, 0);

        // R9 SFR read pins
        access(20'h00200, 1'b0, 2'b10, 16'h6543, 0, len);
        chk(sa_cs == 4'hF && !sa_ale && sa_addr == 20'h00200, "R9 SFR pins",
            {sa_cs, sa_ale}, 5'h1E);
        chk(!sb_rd && !sb_doe && sb_bhe == 1'b0, "R9 SFR read strobe", {sb_rd, sb_doe, sb_bhe}, 0);

        // R8 internal after high-byte write: address and bhe hold
        access(20'hE0080, 1'b1, 2'b11, 16'h0BAD, 0, len);
        access(20'h10000, 1'b1, 2'b01, 16'hFFFF, 0, len);
        chk(len == 1, "R8 internal length", len, 1);
        chk(sa_addr == 20'hE0080 && sa_bhe == 1'b0, "R8 address and bhe hold",
            {sa_addr, sa_bhe}, {20'hE0080, 1'b0});
        chk(sa_cs == 4'hF && !sa_ale && sa_rd && sa_wr && !sa_doe, "R8 parked pins",
            {sa_cs, sa_ale, sa_rd, sa_wr, sa_doe}, 8'hF6);

        // R9 long SFR mode
        cfg_write(2'd2, 8'h01, 1'b0, "R9 mode write");
        access(20'h00004, 1'b0, 2'b11, 16'h3030, 5, len);
        chk(len == 3, "R9 long SFR", len, 3);

        // R2 reserved code rejected, CS3 keeps one wait
        cfg_write(2'd1, 8'hE1, 1'b1, "R2 reserved rejected");
        access(20'hE0000, 1'b0, 2'b11, 16'h4444, 0, len);
        chk(len == 3, "R4 CS3 unchanged", len, 3);

        // R3 code write to no-wait window rejected
        cfg_write(2'd1, 8'h25, 1'b1, "R3 code on nowait window");
        access(20'hA0000, 1'b0, 2'b11, 16'h5555, 0, len);
        chk(len == 2, "R3 CS1 still no wait", len, 2);
        access(20'h80000, 1'b0, 2'b11, 16'h5656, 0, len);
        chk(len == 4, "R4 CS0 code unchanged", len, 4);

        // R3 no-wait set with nonzero code rejected
        cfg_write(2'd0, 8'h03, 1'b1, "R3 nowait with code");
        access(20'h80000, 1'b0, 2'b11, 16'h6666, 6, len);
        chk(len == 6, "R3 CS0 still waited with ready", len, 6);

        // R3 legal order: clear code then set no-wait
        cfg_write(2'd1, 8'h20, 1'b0, "R3 clear code");
        cfg_write(2'd0, 8'h03, 1'b0, "R3 nowait after clear");
        access(20'h80000, 1'b0, 2'b11, 16'h7878, 7, len);
        chk(len == 2, "R3 R7 CS0 now no wait", len, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule